// File: doc/BRIEF.md
# Deadline Scheduler Task Leaf

This block is the leaf of a tree-structured hardware deadline scheduler. Each instance stands for one task. It keeps the task's static timing parameters and its live progress: time left in the period, time left to the deadline and execution time still owed. It also runs a second, independent pair of counters that walk forward through future time for a slack search. The tree above feeds it one command per cycle. One cycle later the leaf returns a single data word for the tree to combine: its deadline with its identifier when a minimum is being selected, or its share of the demand sums when the search steps forward.

The task's life is a small state machine with four named states. UNLOADED is the reset state. IDLE means the activation is complete. READY and RUNNING are the active states. The transitions are:
- LOAD enters READY from any state.
- A real-time TICK that ends the period enters READY from IDLE, READY or RUNNING. This is a new activation, and it wins over a completion in the same tick.
- A TICK that drains the last unit of execution moves RUNNING to IDLE.
- DISPATCH naming this task moves READY to RUNNING. DISPATCH naming another task moves RUNNING to READY.
- FINISH naming this task moves READY or RUNNING to IDLE.

A restart of the search snapshots the live counters into the look-ahead pair. It also saves the remaining execution time of an active task, so that the first deadline met in the look-ahead accounts for only that remainder.

Top module: `sched_leaf`

## Requirements
- R1: After reset, `task_state` is 3 (UNLOADED), `out_valid` is 0 and `out_op`, `out_data` and `out_id` are 0. UNLOADED is left only by LOAD; TICK, DISPATCH and FINISH have no effect on it.
- R2: LOAD (op 0) stores period, deadline and execution time from `prm_period`, `prm_deadline` and `prm_wcet`. It copies the same three values into the live counters and sets `task_state` to 1 (READY). Its output word is 0.
- R3: TICK (op 5), in any loaded state, handles period expiry first. If the live period is 1, all three live counters reload from the stored parameters and the state becomes READY, even if the task was RUNNING with one unit left. Otherwise the period counter decrements and a nonzero deadline counter decrements. In RUNNING, a nonzero execution counter decrements, and a counter of 1 or less moves the state to 0 (IDLE). Output word 0.
- R4: DISPATCH (op 6) with `cmd_arg` equal to TASK_ID moves READY to RUNNING (2). DISPATCH with another value moves RUNNING to READY. FINISH (op 7) with `cmd_arg` equal to TASK_ID moves READY or RUNNING to IDLE. Every other case leaves the state unchanged. Output word 0.
- R5: REPORT (op 4) returns the live deadline counter when the state is READY or RUNNING, and 16'hFFFF otherwise. `out_id` is TASK_ID for REPORT and 0 for every other op.
- R6: RESTART (op 1) loads the look-ahead deadline counter from the live deadline and the look-ahead period counter from the live period. In READY or RUNNING it saves the live execution counter as the saved remainder, sets the restart flag and outputs that remainder. Otherwise it saves 0, clears the flag and outputs 0.
- R7: HSTEP (op 2) decrements the look-ahead deadline counter, modulo 2^16. If the result is 0, the output is the saved remainder and the flag clears when the restart flag is set; otherwise the output is the stored execution time. If the result is not 0, the output is 0.
- R8: GSTEP (op 3) decrements the look-ahead period counter, modulo 2^16. If the result is 0, that counter reloads with the stored period, the look-ahead deadline counter grows by the stored period, and the output is the stored execution time. Otherwise the output is 0.
- R9: One cycle after a cycle with `cmd_valid` high, `out_valid` is 1 and `out_op` equals that command's op. After a cycle with `cmd_valid` low, `out_valid`, `out_op`, `out_data` and `out_id` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 3 | Command code (0 LOAD, 1 RESTART, 2 HSTEP, 3 GSTEP, 4 REPORT, 5 TICK, 6 DISPATCH, 7 FINISH) |
| cmd_arg | input | ID_W | Task identifier for DISPATCH and FINISH |
| prm_period | input | DATA_W | Period for LOAD |
| prm_deadline | input | DATA_W | Relative deadline for LOAD |
| prm_wcet | input | DATA_W | Worst-case execution time for LOAD |
| out_valid | output | 1 | Result word present |
| out_op | output | 3 | Op the result belongs to |
| out_data | output | DATA_W | Deadline, restart remainder, H share or G share |
| out_id | output | ID_W | Task identifier on REPORT results |
| task_state | output | 3 | Task state (0 IDLE, 1 READY, 2 RUNNING, 3 UNLOADED) |

## Verification
Two pairs of this block's functions meet in a single cycle, and the bench drives both.

The first pair is completion and activation. A RUNNING task is loaded with execution time equal to its period, so that the tick ending the period is also the tick that drains the last unit. The state must land in READY with full counters, not in IDLE.

The second pair is the first deadline met after a restart and the restart flag. The restart is issued while the task is RUNNING with part of its execution time spent. The H step that brings the look-ahead deadline to zero must return the smaller saved remainder, and the next deadline must return the full execution time.

A long pseudo-random command stream, compared every cycle with a behavioural model, also makes G-step period reloads land just before H steps that reach the shifted deadline.

// File: rtl/sched_leaf_pkg.sv
package sched_leaf_pkg;

    typedef enum logic [2:0] {
        OP_LOAD     = 3'd0,
        OP_RESTART  = 3'd1,
        OP_HSTEP    = 3'd2,
        OP_GSTEP    = 3'd3,
        OP_REPORT   = 3'd4,
        OP_TICK     = 3'd5,
        OP_DISPATCH = 3'd6,
        OP_FINISH   = 3'd7
    } leaf_op_e;

    typedef enum logic [2:0] {
        TS_IDLE     = 3'd0,
        TS_READY    = 3'd1,
        TS_RUNNING  = 3'd2,
        TS_UNLOADED = 3'd3
    } task_state_e;

    function automatic logic is_active(input task_state_e s);
        return (s == TS_READY) || (s == TS_RUNNING);
    endfunction

endpackage

// File: rtl/leaf_task_fsm.sv
module leaf_task_fsm
    import sched_leaf_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ID_W = 8,
    parameter logic [ID_W-1:0] TASK_ID = 8'h2A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  leaf_op_e          cmd_op,
    input  logic [ID_W-1:0]   cmd_arg,
    input  logic [DATA_W-1:0] prm_period,
    input  logic [DATA_W-1:0] prm_deadline,
    input  logic [DATA_W-1:0] prm_wcet,
    output task_state_e       state,
    output logic [DATA_W-1:0] stat_period,
    output logic [DATA_W-1:0] stat_wcet,
    output logic [DATA_W-1:0] live_period,
    output logic [DATA_W-1:0] live_deadline,
    output logic [DATA_W-1:0] live_exec
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    task_state_e       state_q, state_d;
    logic [DATA_W-1:0] stat_deadline;
    logic              do_load, do_tick, do_disp, do_fin, id_hit, period_end;

    assign do_load    = cmd_valid && (cmd_op == OP_LOAD);
    assign do_tick    = cmd_valid && (cmd_op == OP_TICK) && (state_q != TS_UNLOADED);
    assign do_disp    = cmd_valid && (cmd_op == OP_DISPATCH);
    assign do_fin     = cmd_valid && (cmd_op == OP_FINISH);
    assign id_hit     = (cmd_arg == TASK_ID);
    assign period_end = (live_period == ONE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TS_UNLOADED;
        else        state_q <= state_d;
    end

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TS_UNLOADED: begin
                if (do_load) state_d = TS_READY;
            end
            TS_IDLE: begin
                if (do_load)                     state_d = TS_READY;
                else if (do_tick && period_end)  state_d = TS_READY;
            end
            TS_READY: begin
                if (do_load)                     state_d = TS_READY;
                else if (do_tick && period_end)  state_d = TS_READY;
                else if (do_disp && id_hit)      state_d = TS_RUNNING;
                else if (do_fin && id_hit)       state_d = TS_IDLE;
            end
            TS_RUNNING: begin
                if (do_load)                     state_d = TS_READY;
                else if (do_tick && period_end)  state_d = TS_READY;
                else if (do_tick && live_exec <= ONE) state_d = TS_IDLE;
                else if (do_disp && !id_hit)     state_d = TS_READY;
                else if (do_fin && id_hit)       state_d = TS_IDLE;
            end
            default: state_d = TS_UNLOADED;
        endcase
    end

    // parameter and live counter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_period   <= '0;
            stat_deadline <= '0;
            stat_wcet     <= '0;
            live_period   <= '0;
            live_deadline <= '0;
            live_exec     <= '0;
        end else if (do_load) begin
            stat_period   <= prm_period;
            stat_deadline <= prm_deadline;
            stat_wcet     <= prm_wcet;
            live_period   <= prm_period;
            live_deadline <= prm_deadline;
            live_exec     <= prm_wcet;
        end else if (do_tick) begin
            if (period_end) begin
                live_period   <= stat_period;
                live_deadline <= stat_deadline;
                live_exec     <= stat_wcet;
            end else begin
                live_period <= live_period - ONE;
                if (live_deadline != '0) live_deadline <= live_deadline - ONE;
                if (state_q == TS_RUNNING && live_exec != '0) live_exec <= live_exec - ONE;
            end
        end
    end

    assign state = state_q;

endmodule

// File: rtl/leaf_lookahead.sv
module leaf_lookahead
    import sched_leaf_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  leaf_op_e          cmd_op,
    input  logic              active,
    input  logic [DATA_W-1:0] stat_period,
    input  logic [DATA_W-1:0] stat_wcet,
    input  logic [DATA_W-1:0] live_period,
    input  logic [DATA_W-1:0] live_deadline,
    input  logic [DATA_W-1:0] live_exec,
    output logic [DATA_W-1:0] restart_word,
    output logic [DATA_W-1:0] h_word,
    output logic [DATA_W-1:0] g_word
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    logic [DATA_W-1:0] la_period, la_deadline, saved_rem;
    logic              rst_flag;
    logic [DATA_W-1:0] la_deadline_dec, la_period_dec;
    logic              h_hit, g_hit;

    assign la_deadline_dec = la_deadline - ONE;
    assign la_period_dec   = la_period - ONE;
    assign h_hit           = (la_deadline_dec == '0);
    assign g_hit           = (la_period_dec == '0);

    assign restart_word = active ? live_exec : '0;
    assign h_word       = !h_hit ? '0 : (rst_flag ? saved_rem : stat_wcet);
    assign g_word       = g_hit ? stat_wcet : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            la_period   <= '0;
            la_deadline <= '0;
            saved_rem   <= '0;
            rst_flag    <= 1'b0;
        end else if (cmd_valid) begin
            case (cmd_op)
                OP_RESTART: begin
                    la_deadline <= live_deadline;
                    la_period   <= live_period;
                    saved_rem   <= restart_word;
                    rst_flag    <= active;
                end
                OP_HSTEP: begin
                    la_deadline <= la_deadline_dec;
                    if (h_hit) rst_flag <= 1'b0;
                end
                OP_GSTEP: begin
                    if (g_hit) begin
                        la_period   <= stat_period;
                        la_deadline <= la_deadline + stat_period;
                    end else begin
                        la_period <= la_period_dec;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/leaf_out_sel.sv
module leaf_out_sel
    import sched_leaf_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ID_W = 8,
    parameter logic [ID_W-1:0] TASK_ID = 8'h2A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  leaf_op_e          cmd_op,
    input  logic              active,
    input  logic [DATA_W-1:0] live_deadline,
    input  logic [DATA_W-1:0] restart_word,
    input  logic [DATA_W-1:0] h_word,
    input  logic [DATA_W-1:0] g_word,
    output logic              out_valid,
    output logic [2:0]        out_op,
    output logic [DATA_W-1:0] out_data,
    output logic [ID_W-1:0]   out_id
);

    logic [DATA_W-1:0] word_d;
    logic [ID_W-1:0]   id_d;

    always_comb begin
        id_d = '0;
        unique case (cmd_op)
            OP_REPORT: begin
                word_d = active ? live_deadline : '1;
                id_d   = TASK_ID;
            end
            OP_RESTART: word_d = restart_word;
            OP_HSTEP:   word_d = h_word;
            OP_GSTEP:   word_d = g_word;
            default:    word_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !cmd_valid) begin
            out_valid <= 1'b0;
            out_op    <= '0;
            out_data  <= '0;
            out_id    <= '0;
        end else begin
            out_valid <= 1'b1;
            out_op    <= cmd_op;
            out_data  <= word_d;
            out_id    <= id_d;
        end
    end

endmodule

// File: rtl/sched_leaf.sv
module sched_leaf
    import sched_leaf_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ID_W = 8,
    parameter logic [ID_W-1:0] TASK_ID = 8'h2A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ID_W-1:0]   cmd_arg,
    input  logic [DATA_W-1:0] prm_period,
    input  logic [DATA_W-1:0] prm_deadline,
    input  logic [DATA_W-1:0] prm_wcet,
    output logic              out_valid,
    output logic [2:0]        out_op,
    output logic [DATA_W-1:0] out_data,
    output logic [ID_W-1:0]   out_id,
    output logic [2:0]        task_state
);

    leaf_op_e          op;
    task_state_e       st;
    logic              active;
    logic [DATA_W-1:0] stat_period, stat_wcet;
    logic [DATA_W-1:0] live_period, live_deadline, live_exec;
    logic [DATA_W-1:0] restart_word, h_word, g_word;

    assign op         = leaf_op_e'(cmd_op);
    assign active     = is_active(st);
    assign task_state = st;

    leaf_task_fsm #(.DATA_W(DATA_W), .ID_W(ID_W), .TASK_ID(TASK_ID)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(op), .cmd_arg(cmd_arg),
        .prm_period(prm_period), .prm_deadline(prm_deadline), .prm_wcet(prm_wcet),
        .state(st), .stat_period(stat_period), .stat_wcet(stat_wcet),
        .live_period(live_period), .live_deadline(live_deadline), .live_exec(live_exec)
    );

    leaf_lookahead #(.DATA_W(DATA_W)) u_look (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(op), .active(active),
        .stat_period(stat_period), .stat_wcet(stat_wcet),
        .live_period(live_period), .live_deadline(live_deadline), .live_exec(live_exec),
        .restart_word(restart_word), .h_word(h_word), .g_word(g_word)
    );

    leaf_out_sel #(.DATA_W(DATA_W), .ID_W(ID_W), .TASK_ID(TASK_ID)) u_out (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(op), .active(active),
        .live_deadline(live_deadline), .restart_word(restart_word),
        .h_word(h_word), .g_word(g_word),
        .out_valid(out_valid), .out_op(out_op), .out_data(out_data), .out_id(out_id)
    );

endmodule

// File: rtl/sched_leaf_chk.sv
module sched_leaf_chk #(
    parameter int DATA_W = 16,
    parameter int ID_W = 8,
    parameter logic [ID_W-1:0] TASK_ID = 8'h2A
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [2:0]        cmd_op,
    input logic [ID_W-1:0]   cmd_arg,
    input logic              out_valid,
    input logic [2:0]        out_op,
    input logic [DATA_W-1:0] out_data,
    input logic [ID_W-1:0]   out_id,
    input logic [2:0]        task_state
);

    logic act;
    assign act = (task_state == 3'd1) || (task_state == 3'd2);

    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> (out_valid && out_op == $past(cmd_op)));

    assert_quiet_output_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> (!out_valid && out_data == '0 && out_id == '0));

    assert_load_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd0) |=> (task_state == 3'd1));

    assert_report_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd4 && !act) |=> (out_data == '1 && out_id == TASK_ID));

    assert_finish_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd7 && cmd_arg == TASK_ID && act) |=> (task_state == 3'd0));

    assert_unloaded_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (task_state == 3'd3 && !(cmd_valid && cmd_op == 3'd0)) |=> (task_state == 3'd3));

endmodule

bind sched_leaf sched_leaf_chk #(.DATA_W(DATA_W), .ID_W(ID_W), .TASK_ID(TASK_ID)) i_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
    .out_valid(out_valid), .out_op(out_op), .out_data(out_data), .out_id(out_id),
    .task_state(task_state)
);

// File: tb/test_sched_leaf.sv
`timescale 1ns/1ps
module test_sched_leaf;

    localparam logic [7:0] TID = 8'h2A;
    localparam int M = 16'hFFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [7:0]  cmd_arg = '0;
    logic [15:0] prm_period = '0, prm_deadline = '0, prm_wcet = '0;
    logic        out_valid;
    logic [2:0]  out_op;
    logic [15:0] out_data;
    logic [7:0]  out_id;
    logic [2:0]  task_state;

    always #2.5 clk = ~clk;

    sched_leaf #(.DATA_W(16), .ID_W(8), .TASK_ID(TID)) i_sched_leaf (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
        .prm_period(prm_period), .prm_deadline(prm_deadline), .prm_wcet(prm_wcet),
        .out_valid(out_valid), .out_op(out_op), .out_data(out_data), .out_id(out_id),
        .task_state(task_state)
    );

    int checks = 0, failures = 0;
    bit done = 0;

    // behavioural reference state
    int m_pk, m_dk, m_ck, m_p, m_d, m_c, m_st;
    int m_pf, m_df, m_rem, m_flag;
    int e_valid, e_op, e_data, e_id;
    string e_tag;
    int unsigned rng = 32'h1234_5678;

    function automatic int unsigned nxt();
        rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
        return rng;
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_pk = 0; m_dk = 0; m_ck = 0; m_p = 0; m_d = 0; m_c = 0; m_st = 3;
        m_pf = 0; m_df = 0; m_rem = 0; m_flag = 0;
        e_valid = 0; e_op = 0; e_data = 0; e_id = 0; e_tag = "R1";
    endtask

    // compare the previous command's result, then apply a new command
    task automatic step(bit v, int op, int arg = 0, int p = 0, int d = 0, int c = 0);
        int act;
        @(negedge clk);
        check(e_tag, "out_valid", out_valid, e_valid);
        check(e_tag, "out_op/id/data", {out_op, out_id, out_data}, {e_op[2:0], e_id[7:0], e_data[15:0]});
        check(e_tag, "task_state", task_state, m_st);
        cmd_valid = v; cmd_op = op[2:0]; cmd_arg = arg[7:0];
        prm_period = p[15:0]; prm_deadline = d[15:0]; prm_wcet = c[15:0];
        act = (m_st == 1 || m_st == 2);
        e_valid = v; e_op = v ? op : 0; e_data = 0; e_id = 0; e_tag = "R9";
        if (v) begin
            case (op)
                0: begin e_tag = "R2"; m_pk = p; m_dk = d; m_ck = c; m_p = p; m_d = d; m_c = c; m_st = 1; end
                1: begin
                    e_tag = "R6"; m_df = m_d; m_pf = m_p; m_rem = act ? m_c : 0; m_flag = act; e_data = m_rem;
                end
                2: begin
                    e_tag = "R7"; m_df = (m_df - 1) & M;
                    if (m_df == 0) begin e_data = m_flag ? m_rem : m_ck; m_flag = 0; end
                end
                3: begin
                    e_tag = "R8"; m_pf = (m_pf - 1) & M;
                    if (m_pf == 0) begin m_pf = m_pk; m_df = (m_df + m_pk) & M; e_data = m_ck; end
                end
                4: begin e_tag = "R5"; e_data = act ? m_d : M; e_id = TID; end
                5: begin
                    e_tag = "R3";
                    if (m_st != 3) begin
                        if (m_p == 1) begin m_p = m_pk; m_d = m_dk; m_c = m_ck; m_st = 1; end
                        else begin
                            m_p = (m_p - 1) & M;
                            if (m_d != 0) m_d--;
                            if (m_st == 2) begin
                                if (m_c <= 1) m_st = 0;
                                if (m_c != 0) m_c--;
                            end
                        end
                    end
                end
                6: begin
                    e_tag = "R4";
                    if (m_st == 1 && arg == TID) m_st = 2;
                    else if (m_st == 2 && arg != TID) m_st = 1;
                end
                default: begin e_tag = "R4"; if (act && arg == TID) m_st = 0; end
            endcase
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1", "reset out_valid", out_valid, 0);
        check("R1", "reset out_data", out_data, 0);
        check("R1", "reset task_state", task_state, 3);
        @(negedge clk); rst_n = 1'b1;
        // R1: unloaded ignores tick, dispatch, finish
        step(1, 5); step(1, 6, TID); step(1, 7, TID); step(1, 4); step(0, 0);
        // R2/R5/R6/R7/R8: load, report, restart and look-ahead walk
        step(1, 0, 0, 6, 4, 2); step(1, 4); step(1, 1);
        for (int i = 0; i < 4; i++) step(1, 2);
        for (int i = 0; i < 6; i++) step(1, 3);
        for (int i = 0; i < 6; i++) step(1, 2);
        // R4/R3: dispatch, run to completion, idle report
        step(1, 6, TID); step(1, 5); step(1, 1); step(1, 5); step(1, 4);
        step(1, 1); step(1, 2); step(1, 2); step(1, 2);
        step(1, 7, TID);
        for (int i = 0; i < 5; i++) step(1, 5);
        step(1, 4);
        // R7: restart while running mid-execution gives the saved remainder first
        step(1, 0, 0, 9, 5, 4); step(1, 6, TID); step(1, 5); step(1, 1);
        for (int i = 0; i < 5; i++) step(1, 2);
        step(1, 3); step(1, 3);
        for (int i = 0; i < 12; i++) step(1, (i % 3 == 0) ? 3 : 2);
        // R3: completion and period end in the same tick
        step(1, 0, 0, 2, 2, 2); step(1, 6, TID); step(1, 5); step(1, 5); step(1, 4);
        // R4: dispatch of other id, finish of other id
        step(1, 6, 8'h11); step(1, 6, TID); step(1, 7, 8'h11); step(1, 6, 8'h11); step(1, 7, TID);
        step(0, 0);
        // mixed stream
        for (int n = 0; n < 4000; n++) begin
            int unsigned r, sel, pp, dd, cc;
            r = nxt(); sel = r % 17;
            if (sel == 16) step(0, 0);
            else if (sel == 0) begin
                pp = 3 + nxt() % 8; dd = 1 + nxt() % pp; cc = 1 + nxt() % dd;
                step(1, 0, 0, pp, dd, cc);
            end
            else if (sel <= 2) step(1, 1);
            else if (sel <= 6) step(1, 2);
            else if (sel <= 9) step(1, 3);
            else if (sel <= 10) step(1, 4);
            else if (sel <= 13) step(1, 5);
            else if (sel <= 14) step(1, 6, (nxt() % 2) ? TID : 8'h07);
            else step(1, 7, (nxt() % 4) ? 8'h07 : TID);
        end
        step(0, 0); step(0, 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule